// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the host-facing register file of a four-channel DMA controller. A host programs it through a byte-wide port with a 4-bit register offset and separate write and read strobes. Each channel has a 16-bit transfer address and a 16-bit transfer count. Both pass through the 8-bit port as two accesses, and one shared byte-pointer flip-flop decides whether an access reaches the low byte or the high byte. Separate offsets hold a command byte, a status byte, per-channel mode fields, and several ways to change the channel mask bits. There is also a pointer clear and a master reset.

The transfer engine, which is outside this block, drives a one-cycle step for a channel after each transfer. A step moves the current address up by one and the current count down by one. A step that finds the current count at zero marks terminal count. The channel then either wraps its count or, with auto-initialisation, reloads both current values from the base copies. The engine reads back the per-channel mask, mode and command outputs. It also supplies live request levels, which appear in the status byte.

Top module: `dma_regif`

## Requirements
- R1: Channel c has its address port at offset 2c and its count port at offset 2c+1. A write to either port loads the selected byte (low when the byte pointer is 0, high when it is 1) into both the base copy and the current copy. A read returns the selected byte of the current copy.
- R2: The byte pointer is 0 after reset. Every read or write at offsets 0x0 to 0x7 inverts it.
- R3: Any write to offset 0xC sets the byte pointer to 0, whatever the data.
- R4: A write to offset 0xA changes only the mask bit of channel wdata[1:0]. It sets the bit when wdata[2] is 1 and clears it when wdata[2] is 0.
- R5: A write to offset 0xB stores wdata[7:2] as the mode of channel wdata[1:0]. The mode of channel c appears on chan_mode[6c+5:6c].
- R6: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads the mask from wdata[3:0].
- R7: A write to offset 0xD sets all mask bits, clears the byte pointer, clears the command register and clears the terminal-count flags. Addresses, counts and modes are kept.
- R8: A write to offset 0x8 loads cmd_reg. A read of offset 0x8 returns {chan_req, terminal-count flags[3:0]}. Reads at offsets 0x9 to 0xF return 0.
- R9: A status read clears the terminal-count flags. A flag set by a step in the same cycle survives the read.
- R10: A step on a channel adds one to its current address and subtracts one from its current count. A step while the current count is 0 sets the channel's terminal-count flag, so a programmed count of N-1 gives N transfers. A step is ignored in a cycle where the host writes that channel's address or count port.
- R11: When mode bit 2 (byte bit 4, auto-initialise) is set, a terminal-count step reloads the current address and the current count from the base copies instead of advancing them.
- R12: After reset all mask bits are 1, and every address, count, mode, command and flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| chan_req | input | 4 | Live request level per channel |
| xfer_step | input | 4 | One-cycle transfer-done pulse per channel |
| chan_mask | output | 4 | Per-channel mask, 1 = disabled |
| chan_mode | output | 24 | Six mode bits per channel |
| cmd_reg | output | 8 | Command byte |

## Verification
The bench goes after the byte pointer first. Reads toggle it, a clear at 0xC resets it mid-word, and master reset clears it. A design that toggled only on writes, or ignored the clear, would put the next byte into the wrong half and read back swapped values. It then drives a status read in the same cycle that a terminal-count step arrives. A design that let the clear win would lose that flag. The last case is a count of zero with and without auto-initialisation: a wrong design either raises terminal count one step early or late, or advances the address where it should reload it.

// File: rtl/dma_regif_pkg.sv
// Shared constants of the DMA register interface.
// Assumes a 4-bit register offset and an 8-bit host data path.
package dma_regif_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int MODE_W = BYTE_W - CH_W;
    localparam int AUTO_BIT = 2;            // bit inside the stored mode field

    localparam logic [3:0] OFS_CMD_STAT  = 4'h8;
    localparam logic [3:0] OFS_MASK_ONE  = 4'hA;
    localparam logic [3:0] OFS_MODE      = 4'hB;
    localparam logic [3:0] OFS_PTR_CLR   = 4'hC;
    localparam logic [3:0] OFS_MRESET    = 4'hD;
    localparam logic [3:0] OFS_UNMASK    = 4'hE;
    localparam logic [3:0] OFS_MASK_LOAD = 4'hF;
endpackage

// File: rtl/dma_regif_chan.sv
// Register set of one DMA channel: base and current address and count,
// plus the stored mode field. Byte loads arrive pre-decoded from the top.
// Assumes WORD_W equals two bytes. A load of either word blocks a step.
module dma_regif_chan
    import dma_regif_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int MW = MODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_cnt,
    input  logic          hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic          ld_mode,
    input  logic [MW-1:0] mode_in,
    input  logic          step,
    output logic [W-1:0]  cur_addr,
    output logic [W-1:0]  cur_cnt,
    output logic [MW-1:0] mode,
    output logic          tc
);
    logic [W-1:0] base_addr;
    logic [W-1:0] base_cnt;
    logic         eff_step;
    logic         reload;

    assign eff_step = step && !ld_addr && !ld_cnt;
    assign tc       = eff_step && (cur_cnt == '0);
    assign reload   = tc && mode[AUTO_BIT];

    // Address words: host byte loads, otherwise advance or reload on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (ld_addr) begin
            if (hi_sel) begin
                base_addr[W-1:BYTE_W] <= wdata;
                cur_addr[W-1:BYTE_W]  <= wdata;
            end else begin
                base_addr[BYTE_W-1:0] <= wdata;
                cur_addr[BYTE_W-1:0]  <= wdata;
            end
        end else if (reload) begin
            cur_addr <= base_addr;
        end else if (eff_step) begin
            cur_addr <= cur_addr + 1'b1;
        end
    end

    // Count words: host byte loads, otherwise count down or reload on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (ld_cnt) begin
            if (hi_sel) begin
                base_cnt[W-1:BYTE_W] <= wdata;
                cur_cnt[W-1:BYTE_W]  <= wdata;
            end else begin
                base_cnt[BYTE_W-1:0] <= wdata;
                cur_cnt[BYTE_W-1:0]  <= wdata;
            end
        end else if (reload) begin
            cur_cnt <= base_cnt;
        end else if (eff_step) begin
            cur_cnt <= cur_cnt - 1'b1;
        end
    end

    // Mode field store.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= '0;
        else if (ld_mode) mode <= mode_in;
    end
endmodule

// File: rtl/dma_regif_status.sv
// Terminal-count flag register. New flags win over a read clear, and
// master reset clears everything.
module dma_regif_status
    import dma_regif_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] tc_set,
    input  logic         rd_clr,
    input  logic         mreset,
    output logic [N-1:0] tc_flags
);
    // Sticky flags with clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n)      tc_flags <= '0;
        else if (mreset) tc_flags <= '0;
        else if (rd_clr) tc_flags <= tc_set;
        else             tc_flags <= tc_flags | tc_set;
    end
endmodule

// File: rtl/dma_regif.sv
// Top of the DMA register interface. Decodes host accesses, holds the
// byte pointer, the mask and the command byte, and builds read data.
// Assumes host_wr and host_rd are never high in the same cycle.
module dma_regif
    import dma_regif_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               host_addr,
    input  logic [BYTE_W-1:0]        host_wdata,
    input  logic                     host_wr,
    input  logic                     host_rd,
    output logic [BYTE_W-1:0]        host_rdata,
    input  logic [NUM_CH-1:0]        chan_req,
    input  logic [NUM_CH-1:0]        xfer_step,
    output logic [NUM_CH-1:0]        chan_mask,
    output logic [NUM_CH*MODE_W-1:0] chan_mode,
    output logic [BYTE_W-1:0]        cmd_reg
);
    logic              byte_ptr;
    logic              port_hit;
    logic              port_acc;
    logic [CH_W-1:0]   acc_ch;
    logic              acc_cnt;
    logic              wr_mreset;
    logic              rd_stat;
    logic [NUM_CH-1:0] tc_set;
    logic [NUM_CH-1:0] tc_flags;
    logic [WORD_W-1:0] cur_addr [NUM_CH];
    logic [WORD_W-1:0] cur_cnt  [NUM_CH];
    logic [MODE_W-1:0] mode     [NUM_CH];

    assign port_hit  = (host_addr[3] == 1'b0);
    assign port_acc  = port_hit && (host_wr || host_rd);
    assign acc_ch    = host_addr[CH_W:1];
    assign acc_cnt   = host_addr[0];
    assign wr_mreset = host_wr && (host_addr == OFS_MRESET);
    assign rd_stat   = host_rd && (host_addr == OFS_CMD_STAT);

    // Byte pointer: cleared by pointer clear or master reset, toggled per port access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byte_ptr <= 1'b0;
        else if (wr_mreset || (host_wr && host_addr == OFS_PTR_CLR))
            byte_ptr <= 1'b0;
        else if (port_acc)
            byte_ptr <= !byte_ptr;
    end

    // Mask bits: four write forms plus master reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan_mask <= '1;
        else if (wr_mreset)
            chan_mask <= '1;
        else if (host_wr && host_addr == OFS_UNMASK)
            chan_mask <= '0;
        else if (host_wr && host_addr == OFS_MASK_LOAD)
            chan_mask <= host_wdata[NUM_CH-1:0];
        else if (host_wr && host_addr == OFS_MASK_ONE)
            chan_mask[host_wdata[CH_W-1:0]] <= host_wdata[CH_W];
    end

    // Command byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         cmd_reg <= '0;
        else if (wr_mreset) cmd_reg <= '0;
        else if (host_wr && host_addr == OFS_CMD_STAT)
            cmd_reg <= host_wdata;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = host_wr && port_hit && (acc_ch == CH_W'(c));

        dma_regif_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_addr  (sel && !acc_cnt),
            .ld_cnt   (sel && acc_cnt),
            .hi_sel   (byte_ptr),
            .wdata    (host_wdata),
            .ld_mode  (host_wr && host_addr == OFS_MODE &&
                       host_wdata[CH_W-1:0] == CH_W'(c)),
            .mode_in  (host_wdata[BYTE_W-1:CH_W]),
            .step     (xfer_step[c]),
            .cur_addr (cur_addr[c]),
            .cur_cnt  (cur_cnt[c]),
            .mode     (mode[c]),
            .tc       (tc_set[c])
        );

        assign chan_mode[c*MODE_W +: MODE_W] = mode[c];
    end

    dma_regif_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_set   (tc_set),
        .rd_clr   (rd_stat),
        .mreset   (wr_mreset),
        .tc_flags (tc_flags)
    );

    // Read data: selected byte of a current word, status, or zero.
    always_comb begin
        logic [WORD_W-1:0] word;
        word = acc_cnt ? cur_cnt[acc_ch] : cur_addr[acc_ch];
        if (port_hit)
            host_rdata = byte_ptr ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
        else if (host_addr == OFS_CMD_STAT)
            host_rdata = {chan_req, tc_flags};
        else
            host_rdata = '0;
    end
endmodule

// File: rtl/dma_regif_chk.sv
// Property checker for dma_regif, attached by bind.
module dma_regif_chk
    import dma_regif_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               host_addr,
    input  logic [BYTE_W-1:0]        host_wdata,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [NUM_CH-1:0]        xfer_step,
    input  logic [NUM_CH-1:0]        chan_mask,
    input  logic [NUM_CH*MODE_W-1:0] chan_mode,
    input  logic [BYTE_W-1:0]        cmd_reg,
    input  logic                     byte_ptr,
    input  logic [NUM_CH-1:0]        tc_flags
);
    assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && !host_addr[3]) |=> (byte_ptr != $past(byte_ptr)));

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_PTR_CLR) |=> (byte_ptr == 1'b0));

    assert_mask_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_MASK_ONE)
        |=> (chan_mask[$past(host_wdata[CH_W-1:0])] == $past(host_wdata[CH_W])));

    assert_mode_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_MODE)
        |=> (chan_mode[$past(host_wdata[CH_W-1:0]) * MODE_W +: MODE_W]
             == $past(host_wdata[BYTE_W-1:CH_W])));

    assert_unmask_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_UNMASK) |=> (chan_mask == '0));

    assert_master_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_MRESET)
        |=> (chan_mask == '1 && cmd_reg == '0 && !byte_ptr && tc_flags == '0));

    assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_CMD_STAT && xfer_step == '0)
        |=> (tc_flags == '0));
endmodule

bind dma_regif dma_regif_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .xfer_step  (xfer_step),
    .chan_mask  (chan_mask),
    .chan_mode  (chan_mode),
    .cmd_reg    (cmd_reg),
    .byte_ptr   (byte_ptr),
    .tc_flags   (tc_flags)
);

// File: tb/dma_regif_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module dma_regif_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic [3:0]  chan_req = '0;
    logic [3:0]  xfer_step = '0;
    logic [3:0]  chan_mask;
    logic [23:0] chan_mode;
    logic [7:0]  cmd_reg;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       sample_ev;

    always #5 clk = ~clk;

    dma_regif u_dma_regif (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .chan_req(chan_req), .xfer_step(xfer_step), .chan_mask(chan_mask),
        .chan_mode(chan_mode), .cmd_reg(cmd_reg)
    );

    // Monitor: pops the expected read byte and compares it with the port.
    always begin
        @(sample_ev);
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (host_rdata !== e) begin
                mismatched++;
                $display("FAIL %s: rdata actual %h expected %h", t, host_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e,
                      input logic [3:0] stp, input string t);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1; xfer_step = stp;
        exp_q.push_back(e); tag_q.push_back(t);
        #2 -> sample_ev;
        @(posedge clk); #1;
        host_rd = 1'b0; xfer_step = '0;
    endtask

    task automatic step(input logic [3:0] s);
        @(negedge clk);
        xfer_step = s;
        @(posedge clk); #1;
        xfer_step = '0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        compared++;
        if (act !== e) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12 reset state
        chk(chan_mask, 4'hF, "R12 mask");
        chk(chan_mode, 24'h0, "R12 mode");
        chk(cmd_reg, 8'h00, "R12 cmd");
        rd(4'h8, 8'h00, 4'h0, "R12 status");
        rd(4'h9, 8'h00, 4'h0, "R8 unmapped read");
        // R1 channel 1 address (port 2) and count (port 3)
        wr(4'hC, 8'h00);
        wr(4'h2, 8'h34); wr(4'h2, 8'h12);
        wr(4'h3, 8'h03); wr(4'h3, 8'h00);
        rd(4'h2, 8'h34, 4'h0, "R1 addr lo"); rd(4'h2, 8'h12, 4'h0, "R1 addr hi");
        rd(4'h3, 8'h03, 4'h0, "R1 cnt lo");  rd(4'h3, 8'h00, 4'h0, "R1 cnt hi");
        // R3: pointer clear mid-word with nonzero data, R2: reads toggle too
        wr(4'h2, 8'hAA);
        wr(4'hC, 8'h55);
        rd(4'h2, 8'hAA, 4'h0, "R3 lo after clear");
        rd(4'h2, 8'h12, 4'h0, "R2 hi after read toggle");
        // R1 channel 3 ports 6 and 7
        wr(4'h6, 8'hCD); wr(4'h6, 8'hAB);
        rd(4'h6, 8'hCD, 4'h0, "R1 ch3 lo"); rd(4'h6, 8'hAB, 4'h0, "R1 ch3 hi");
        // R4 / R6 masks
        wr(4'hA, 8'h01); chk(chan_mask, 4'hD, "R4 unmask ch1");
        wr(4'hA, 8'h05); chk(chan_mask, 4'hF, "R4 mask ch1");
        wr(4'hF, 8'hF5); chk(chan_mask, 4'h5, "R6 load all");
        wr(4'hE, 8'hFF); chk(chan_mask, 4'h0, "R6 clear all");
        wr(4'hA, 8'h06); chk(chan_mask, 4'h4, "R4 mask ch2");
        // R5 mode
        wr(4'hB, 8'h49); chk(chan_mode[11:6], 6'h12, "R5 ch1 mode");
        wr(4'hB, 8'h57); chk(chan_mode[23:18], 6'h15, "R5 ch3 mode");
        chk(chan_mode[5:0], 6'h00, "R5 ch0 untouched");
        // R8 command
        wr(4'h8, 8'hA5); chk(cmd_reg, 8'hA5, "R8 cmd");
        // R10 ch1: count 3, addr 0x12AA, no auto-init
        chan_req = 4'b1010;
        step(4'h2); step(4'h2); step(4'h2);
        rd(4'h8, 8'hA0, 4'h0, "R10 no tc before last");
        step(4'h2);
        rd(4'h8, 8'hA2, 4'h0, "R10 tc on fourth step");
        rd(4'h8, 8'hA0, 4'h0, "R9 cleared by read");
        wr(4'hC, 8'h00);
        rd(4'h2, 8'hAE, 4'h0, "R10 addr lo"); rd(4'h2, 8'h12, 4'h0, "R10 addr hi");
        rd(4'h3, 8'hFF, 4'h0, "R10 cnt lo");  rd(4'h3, 8'hFF, 4'h0, "R10 cnt hi");
        // R11 ch0 auto-init, count 0
        wr(4'h0, 8'h10); wr(4'h0, 8'h00);
        wr(4'h1, 8'h00); wr(4'h1, 8'h00);
        wr(4'hB, 8'h54);
        rd(4'h8, 8'hA0, 4'h1, "R9 same-cycle step read");
        rd(4'h8, 8'hA1, 4'h0, "R9 flag survived");
        rd(4'h0, 8'h10, 4'h0, "R11 addr lo reload");
        rd(4'h0, 8'h00, 4'h0, "R11 addr hi reload");
        rd(4'h1, 8'h00, 4'h0, "R11 cnt lo reload");
        rd(4'h1, 8'h00, 4'h0, "R11 cnt hi reload");
        // R7 master reset with pointer left high and a pending flag
        step(4'h1);
        rd(4'h6, 8'hCD, 4'h0, "R2 ch3 lo");
        wr(4'hD, 8'h00);
        chk(chan_mask, 4'hF, "R7 mask");
        chk(cmd_reg, 8'h00, "R7 cmd");
        chk(chan_mode[11:6], 6'h12, "R7 mode kept");
        rd(4'h8, 8'hA0, 4'h0, "R7 flags cleared");
        rd(4'h6, 8'hCD, 4'h0, "R7 pointer cleared");
        rd(4'h6, 8'hAB, 4'h0, "R7 addr kept");
        repeat (3) @(posedge clk);
        wait (exp_q.size() == 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule